// File: doc/BRIEF.md
# SAR Conversion Sequencer with Framed Serial Output

This block runs a successive-approximation conversion and sends the result out on a framed serial link while the conversion is still running. An asynchronous convert-start edge is brought into the clock domain. The block then switches the track/hold to hold and drives a trial code to an external DAC and comparator. It settles one result bit per serial-clock period from the comparator decision. Each bit is shifted out behind four leading zeros, with the most significant bit first.

The serial clock runs at half the system clock rate and comes from an internal phase register. In continuous mode it toggles all the time and its enable stays on. In gated mode it starts high on the start edge, and its enable drops once the 16-bit frame has been sent. Output enables are separate ports, so a pad ring can model shared open-drain lines. The sequencer counts rising edges of the serial clock. In continuous mode a start that lands just as the clock falls costs one extra rising edge, which models the uncertainty of the synchronizer.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A rising edge on `conv_start_i` is synchronized through two flops plus an edge detector. `frame_n_o` goes low and `hold_o` goes high on the third clock edge after the input rises.
- R2: A frame carries 16 bits. The first four are zero, and the 12-bit result follows with the most significant bit first.
- R3: `sdata_o` changes only on a rising transition of `sclk_o`. A receiver samples it on each falling transition of `sclk_o` for which `frame_n_o` was already low in the cycle before. The first such sample is the first leading zero.
- R4: The result is two's complement: the top bit of the offset-binary trial register is inverted. With `cmp_i = 1` meaning the input is at or above the trial code, an input level of 0 gives 0x800, 4095 gives 0x7FF, 2048 gives 0x000 and 2047 gives 0xFFF.
- R5: On the start edge, `trial_o` is loaded with 0x800. Each counted rising edge of the serial clock then fixes one bit from `cmp_i` and raises the next lower bit, 12 decisions in all.
- R6: In continuous mode (`free_clk_i = 1`), the conversion ends on the 19th rising edge of `sclk_o` after the start edge. If `sclk_o` falls on the start edge itself, it ends on the 20th.
- R7: In gated mode (`free_clk_i = 0`), `sclk_o` is driven high on the start edge, and the conversion always ends on the 19th rising edge after it.
- R8: In gated mode, `sclk_oe_o` is high exactly while the frame strobe is low and low otherwise. In continuous mode it stays high.
- R9: On the 16th counted rising edge, `frame_n_o` returns high and `sdata_oe_o` falls. `sdata_oe_o` is high exactly while `frame_n_o` is low.
- R10: `busy_o` and `hold_o` stay high from the start edge until the conversion ends. A convert-start edge that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_i | input | 1 | Asynchronous convert request; its rising edge starts a conversion |
| free_clk_i | input | 1 | 1 = continuous serial clock, 0 = gated serial clock |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| trial_o | output | 12 | Offset-binary trial code sent to the external DAC |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| frame_n_o | output | 1 | Active-low frame strobe |
| sclk_o | output | 1 | Serial clock |
| sclk_oe_o | output | 1 | Drive enable for the serial clock |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Drive enable for the serial data |
| busy_o | output | 1 | Conversion in progress |

## Verification
The frame strobe and hold are due on the third clock edge after the convert-start input rises, so the bench drives the request on a falling edge and expects them in the third sample after it. The end of conversion is counted in rising edges of the serial clock, not in system clocks. The bench reads the serial clock level in the sample just after the start edge, sets 19 or 20 as the expected count from that level and the mode, and counts rising transitions until busy drops. Data bits are captured only on serial-clock falls that follow a cycle in which the strobe was low, which is the sampling rule of R3. The enables, hold and busy are compared against the strobe and the mode on every clock.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic {
    SCLK_GATED = 1'b0,
    SCLK_FREE  = 1'b1
  } sclk_mode_e;

  localparam int unsigned DEF_WIDTH      = 12;
  localparam int unsigned DEF_LEAD       = 4;
  localparam int unsigned DEF_CONV_EDGES = 19;
  localparam int unsigned DEF_SYNC       = 2;

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic pulse_o
);

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_i};
  end

  assign pulse_o = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen (
  input  logic clk,
  input  logic rst,
  input  logic force_hi,
  output logic ph_o
);

  always_ff @(posedge clk) begin
    if (rst)           ph_o <= 1'b0;
    else if (force_hi) ph_o <= 1'b1;
    else               ph_o <= ~ph_o;
  end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int unsigned WIDTH = 12,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             decide,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp,
  output logic [WIDTH-1:0] trial_o
);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = trial_o;
    if (load) begin
      nxt = '0;
      nxt[WIDTH-1] = 1'b1;
    end else if (decide) begin
      for (int i = 0; i < int'(WIDTH); i++)
        if (i == int'(bit_idx)) nxt[i] = cmp;
      for (int i = 0; i < int'(WIDTH) - 1; i++)
        if (i + 1 == int'(bit_idx)) nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trial_o <= '0;
    else     trial_o <= nxt;
  end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned LEAD        = DEF_LEAD,
  parameter int unsigned CONV_EDGES  = DEF_CONV_EDGES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start_i,
  input  logic             free_clk_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             hold_o,
  output logic             frame_n_o,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             busy_o
);

  localparam int unsigned FRAME  = LEAD + WIDTH;
  localparam int unsigned STEP_W = $clog2(CONV_EDGES + 1);
  localparam int unsigned IDX_W  = $clog2(WIDTH);

  logic              start_pulse, start_go, free_mode;
  logic              ph, rise, adv, skip, gate, gate_d;
  logic [STEP_W-1:0] step, nstep, dec_pos, ser_pos;
  logic              dec_en, ser_bit;
  logic [WIDTH-1:0]  result;

  assign free_mode = (sclk_mode_e'(free_clk_i) == SCLK_FREE);

  sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(conv_start_i), .pulse_o(start_pulse)
  );

  assign start_go = start_pulse & ~busy_o;

  sar_sclk_gen u_sclk (
    .clk(clk), .rst(rst), .force_hi(start_go & ~free_mode), .ph_o(ph)
  );

  // the coming edge is a rising edge of the serial clock when the phase is low
  assign rise   = ~ph;
  assign adv    = busy_o & rise & ~skip;
  assign nstep  = step + 1'b1;
  assign dec_en = adv && (nstep <= STEP_W'(WIDTH));
  assign dec_pos = STEP_W'(WIDTH) - nstep;

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk(clk), .rst(rst), .load(start_go), .decide(dec_en),
    .bit_idx(dec_pos[IDX_W-1:0]), .cmp(cmp_i), .trial_o(trial_o)
  );

  // two's-complement view of the settled bits
  assign result  = {~trial_o[WIDTH-1], trial_o[WIDTH-2:0]};
  assign ser_pos = STEP_W'(FRAME - 1) - nstep;
  assign ser_bit = (nstep < STEP_W'(LEAD)) ? 1'b0 : result[ser_pos[IDX_W-1:0]];

  always_comb begin
    gate_d = gate;
    if (start_go)                          gate_d = 1'b1;
    else if (adv && nstep == STEP_W'(FRAME)) gate_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o     <= 1'b0;
      hold_o     <= 1'b0;
      skip       <= 1'b0;
      step       <= '0;
      frame_n_o  <= 1'b1;
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
      gate       <= 1'b0;
      sclk_oe_o  <= 1'b0;
    end else begin
      gate      <= gate_d;
      sclk_oe_o <= free_mode | gate_d;
      if (start_go) begin
        busy_o     <= 1'b1;
        hold_o     <= 1'b1;
        skip       <= free_mode & ph;
        step       <= '0;
        frame_n_o  <= 1'b0;
        sdata_o    <= 1'b0;
        sdata_oe_o <= 1'b1;
      end else if (busy_o && rise) begin
        if (skip) begin
          skip <= 1'b0;
        end else begin
          step <= nstep;
          if (nstep < STEP_W'(FRAME)) sdata_o <= ser_bit;
          if (nstep == STEP_W'(FRAME)) begin
            frame_n_o  <= 1'b1;
            sdata_o    <= 1'b0;
            sdata_oe_o <= 1'b0;
          end
          if (nstep == STEP_W'(CONV_EDGES)) begin
            busy_o <= 1'b0;
            hold_o <= 1'b0;
          end
        end
      end
    end
  end

  assign sclk_o = ph;

  // R10: a frame only exists inside a conversion
  a_r10_frame_in_busy: assert property (@(posedge clk) disable iff (rst)
    !frame_n_o |-> busy_o);

  // R10: a new frame only begins from idle
  a_r10_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n_o) |-> !$past(busy_o));

  // R3: data moves only with a rising serial clock while framed
  a_r3_data_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!frame_n_o && !$stable(sdata_o)) |-> $rose(sclk_o));

  // R2: leading bits of the frame are zero
  a_r2_lead_zero: assert property (@(posedge clk) disable iff (rst)
    (!frame_n_o && step < STEP_W'(LEAD)) |-> !sdata_o);

  // R7: gated clock is high on the start edge
  a_r7_gated_high_at_start: assert property (@(posedge clk) disable iff (rst)
    ($fell(frame_n_o) && !$past(free_clk_i)) |-> sclk_o);

  // R8: gated clock is released while idle
  a_r8_gated_off_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(free_clk_i) && !$past(busy_o) && !busy_o) |-> !sclk_oe_o);

endmodule

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        free = 1'b0;
  int          vin = 0;
  logic [11:0] trial;
  logic        cmp, hold, frame_n, sclk, sclk_oe, sdata, sdata_oe, busy;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  assign cmp = (int'(trial) <= vin);

  always #2.5 clk = ~clk;

  sar_adc_ctrl i_sar_adc_ctrl (
    .clk(clk), .rst(rst), .conv_start_i(start), .free_clk_i(free), .cmp_i(cmp),
    .trial_o(trial), .hold_o(hold), .frame_n_o(frame_n), .sclk_o(sclk),
    .sclk_oe_o(sclk_oe), .sdata_o(sdata), .sdata_oe_o(sdata_oe), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic conv(input int v, input bit fr, input int pre, input bit poke);
    int exp_rises, rises, nb;
    logic [15:0] word;
    logic prev_s, prev_f;
    vin  = v;
    free = fr;
    repeat (pre + 3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    chk(frame_n === 1'b1, "R1 strobe early 1", int'(frame_n), 1);
    @(negedge clk);
    chk(frame_n === 1'b1, "R1 strobe early 2", int'(frame_n), 1);
    @(negedge clk);
    chk(frame_n === 1'b0, "R1 strobe on third edge", int'(frame_n), 0);
    chk(hold === 1'b1, "R1 hold at start", int'(hold), 1);
    chk(trial === 12'h800, "R5 first trial", int'(trial), 'h800);
    if (!fr) chk(sclk === 1'b1, "R7 gated clock high at start", int'(sclk), 1);
    exp_rises = (fr && sclk === 1'b0) ? 20 : 19;
    rises = 0; nb = 0; word = '0;
    prev_s = sclk; prev_f = frame_n;
    for (int cyc = 0; cyc < 100; cyc++) begin
      @(negedge clk);
      if (cyc == 2) start = 1'b0;
      if (poke && cyc == 10) start = 1'b1;
      if (poke && cyc == 14) start = 1'b0;
      if (prev_s === 1'b0 && sclk === 1'b1) rises++;
      if (prev_s === 1'b1 && sclk === 1'b0 && prev_f === 1'b0 && frame_n === 1'b0) begin
        word = {word[14:0], sdata};
        nb++;
      end
      chk(hold === busy, "R10 hold follows busy", int'(hold), int'(busy));
      chk(sdata_oe === ~frame_n, "R9 data enable vs strobe", int'(sdata_oe), int'(~frame_n));
      chk(sclk_oe === (fr ? 1'b1 : ~frame_n), "R8 clock enable", int'(sclk_oe),
          int'(fr ? 1'b1 : ~frame_n));
      prev_s = sclk; prev_f = frame_n;
      if (busy === 1'b0) break;
    end
    chk(rises == exp_rises, fr ? "R6 continuous edge count" : "R7 gated edge count",
        rises, exp_rises);
    chk(nb == 16, "R3 sampled bit count", nb, 16);
    chk(word == {4'b0000, 12'(v ^ 'h800)}, "R2 R4 serial word", int'(word),
        int'({4'b0000, 12'(v ^ 'h800)}));
    chk(frame_n === 1'b1, "R9 strobe high after frame", int'(frame_n), 1);
    if (!fr) begin
      @(negedge clk);
      chk(sclk_oe === 1'b0, "R8 gated clock released", int'(sclk_oe), 0);
    end
    if (poke) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        chk(frame_n === 1'b1 && busy === 1'b0, "R10 start while busy ignored",
            int'(frame_n), 1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(frame_n === 1'b1, "R9 reset strobe", int'(frame_n), 1);
    chk(busy === 1'b0, "R10 reset busy", int'(busy), 0);
    chk(hold === 1'b0, "R10 reset hold", int'(hold), 0);
    chk(sdata_oe === 1'b0, "R9 reset data enable", int'(sdata_oe), 0);
    chk(sclk_oe === 1'b0, "R8 reset clock enable", int'(sclk_oe), 0);
    rst = 1'b0;
    conv(0,    1'b1, 0, 1'b0);
    conv(4095, 1'b1, 1, 1'b0);
    conv(2048, 1'b0, 0, 1'b0);
    conv(2047, 1'b0, 1, 1'b1);
    conv(1234, 1'b1, 0, 1'b1);
    conv(3000, 1'b1, 1, 1'b0);
    conv(1,    1'b1, 2, 1'b0);
    conv(2730, 1'b0, 3, 1'b0);
    conv(1365, 1'b1, 3, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule